// File: doc/BRIEF.md
# Write-Through Store Queue

This block holds processor stores on their way from a write-through cache to a slow DRAM write port. Every store that the processor presents is written to the cache and, in the same cycle, offered to this queue. The queue keeps up to four pending writes, each with a word address, a 32-bit data word and four byte enables. A memory-side controller takes the oldest pending write, presents it to DRAM and holds it there until DRAM acknowledges it. The next write then moves up.

Stores arrive on a valid/stall pair. The store side is a valid/ready stream where ready is sent inverted as `st_stall`. A store counts as accepted on a rising edge where `st_valid` is high and `st_stall` is low. While `st_stall` is high, the processor must hold the store and keep `st_valid` high. The DRAM side is a valid/ready stream. `mem_valid` stays high with a stable payload until `mem_ready` is seen high on an edge. `buf_full` and `buf_empty` report occupancy. `ld_hit` tells a load path whether a store to `ld_addr` is still pending, so that the load can avoid reading stale DRAM data.

Top module: `wt_store_queue`

## Requirements
- R1: After reset the queue is empty: `buf_empty`=1, `buf_full`=0, `mem_valid`=0, `st_stall`=0, `ld_hit`=0.
- R2: Writes leave on `mem_addr`/`mem_data`/`mem_be` in the order their stores were accepted, with address, data and byte enables unchanged.
- R3: The queue holds at most DEPTH=4 entries. `buf_full` is 1 exactly when 4 writes are pending, and `buf_empty` is 1 exactly when none are pending.
- R4: `st_stall` equals `buf_full & st_valid & ~mem_ready`, combinationally. A stalled store is not taken.
- R5: When the queue is full, a store and a DRAM acknowledge in the same cycle do not stall. The store is taken and the queue stays at 4 entries.
- R6: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high and keeps `mem_addr`, `mem_data` and `mem_be` unchanged.
- R7: `ld_hit` is 1 in a cycle exactly when some entry accepted on an earlier edge, and not yet acknowledged, has an address equal to `ld_addr`. A store offered in the same cycle does not count.
- R8: A store accepted into an empty queue shows on `mem_valid` and the DRAM payload in the following cycle, not the same cycle.
- R9: While `st_valid` is low, the queue ignores `st_addr`, `st_data` and `st_be`: no entry is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store offered |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store held off (inverse of ready) |
| mem_valid | output | 1 | DRAM write presented |
| mem_ready | input | 1 | DRAM write acknowledge |
| mem_addr | output | 30 | DRAM write word address |
| mem_data | output | 32 | DRAM write data |
| mem_be | output | 4 | DRAM write byte enables |
| buf_full | output | 1 | Four writes pending |
| buf_empty | output | 1 | No write pending |
| ld_addr | input | 30 | Load word address to compare |
| ld_hit | output | 1 | A pending write matches `ld_addr` |

## Verification
A burst of stores with DRAM held off shows that the queue fills to exactly four entries and then stalls. Continuing that burst with the acknowledge held high separates the stall-on-full rule from the pass-through case, where the queue is full but a write leaves in the same cycle. A phase with no stores, the acknowledge low and junk on the store inputs shows whether the DRAM payload holds and whether idle inputs leak into the queue. A single store into an empty queue exposes any same-cycle bypass. A long pseudo-random run then mixes store density, acknowledge rate and load addresses drawn from recent stores, so ordering, wrap-around and the match output are all tested under every occupancy.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  // next ring index for a buffer of arbitrary depth
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/wtb_ctrl.sv
module wtb_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = wtb_pkg::idx_width(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             mem_ready,
  output logic             push,
  output logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [DEPTH-1:0] live,
  output logic             full,
  output logic             empty,
  output logic             stall
);
  logic [CNT_W-1:0] occ_q;

  assign full  = (occ_q == CNT_W'(DEPTH));
  assign empty = (occ_q == '0);
  assign pop   = ~empty & mem_ready;
  assign stall = full & st_valid & ~mem_ready;
  assign push  = st_valid & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      case ({push, pop})
        2'b10:   occ_q <= occ_q + CNT_W'(1);
        2'b01:   occ_q <= occ_q - CNT_W'(1);
        default: occ_q <= occ_q;
      endcase
      if (push) wr_ptr <= PTR_W'(wtb_pkg::ring_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(wtb_pkg::ring_next(32'(rd_ptr), DEPTH));
    end
  end

  // per-entry occupancy flags used by the address comparators
  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[i] <= 1'b0;
      end else if (push && wr_ptr == PTR_W'(i)) begin
        live[i] <= 1'b1;
      end else if (pop && rd_ptr == PTR_W'(i)) begin
        live[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wtb_entries.sv
module wtb_entries #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = wtb_pkg::idx_width(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_ptr,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [BE_W-1:0]              wr_be,
  input  logic [PTR_W-1:0]             rd_ptr,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [BE_W-1:0]              rd_be,
  output logic [DEPTH-1:0][ADDR_W-1:0] all_addr
);
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0][BE_W-1:0]   be_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        all_addr[i] <= '0;
        data_q[i]   <= '0;
        be_q[i]     <= '0;
      end else if (wr_en && wr_ptr == PTR_W'(i)) begin
        all_addr[i] <= wr_addr;
        data_q[i]   <= wr_data;
        be_q[i]     <= wr_be;
      end
    end
  end

  assign rd_addr = all_addr[rd_ptr];
  assign rd_data = data_q[rd_ptr];
  assign rd_be   = be_q[rd_ptr];
endmodule

// File: rtl/wtb_addr_match.sv
module wtb_addr_match #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 30
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] all_addr,
  input  logic [DEPTH-1:0]             live,
  input  logic [ADDR_W-1:0]            probe,
  output logic                         hit
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = live[i] & (all_addr[i] == probe);
  end

  assign hit = |eq;
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = wtb_pkg::idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_stall,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  output logic              buf_full,
  output logic              buf_empty,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit
);
  logic                         push, pop;
  logic [PTR_W-1:0]             wr_ptr, rd_ptr;
  logic [DEPTH-1:0]             live;
  logic [DEPTH-1:0][ADDR_W-1:0] all_addr;

  wtb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .mem_ready(mem_ready),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .live(live),
    .full(buf_full), .empty(buf_empty), .stall(st_stall)
  );

  wtb_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_ptr(wr_ptr),
    .wr_addr(st_addr), .wr_data(st_data), .wr_be(st_be), .rd_ptr(rd_ptr),
    .rd_addr(mem_addr), .rd_data(mem_data), .rd_be(mem_be), .all_addr(all_addr)
  );

  wtb_addr_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .all_addr(all_addr), .live(live), .probe(ld_addr), .hit(ld_hit)
  );

  assign mem_valid = ~buf_empty;
endmodule

// File: rtl/wtb_checker.sv
module wtb_checker #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_stall,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be,
  input logic              buf_full,
  input logic              buf_empty
);
  // independent occupancy tally from the two handshakes
  logic [CNT_W-1:0] tally;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tally <= '0;
    else tally <= tally + CNT_W'(st_valid && !st_stall) - CNT_W'(mem_valid && mem_ready);
  end

  p_occupancy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full == (tally == CNT_W'(DEPTH))) && (buf_empty == (tally == '0)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && st_valid && !mem_ready) |-> st_stall);
  p_stall_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (buf_full && st_valid));
  p_pass_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && st_valid && mem_ready) |-> !st_stall);
  p_hold_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
  p_drain_presented_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |-> mem_valid);
  p_push_seen_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && st_valid) |=> mem_valid);
endmodule

bind wt_store_queue wtb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_be(mem_be), .buf_full(buf_full), .buf_empty(buf_empty)
);

// File: tb/wt_store_queue_bench.sv
`timescale 1ns/1ps
module wt_store_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic [29:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [3:0]  st_be = '0;
  logic        st_stall, mem_valid, buf_full, buf_empty, ld_hit;
  logic        mem_ready = 1'b0;
  logic [29:0] mem_addr, ld_addr = '0;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;

  int compared = 0;
  int mismatched = 0;

  // reference model
  logic [29:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [3:0]  q_be[$];
  logic        prev_hold = 1'b0;
  logic [29:0] prev_addr;
  logic [31:0] prev_data;
  logic [3:0]  prev_be;
  logic [31:0] lfsr = 32'h1d2c_3b4a;
  int          seq = 0;

  always #2.5 clk = ~clk;

  wt_store_queue u_wt_store_queue (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_stall(st_stall), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be), .buf_full(buf_full),
    .buf_empty(buf_empty), .ld_addr(ld_addr), .ld_hit(ld_hit)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic cyc(input bit sv, input logic [29:0] a, input logic [31:0] d,
                     input logic [3:0] b, input bit mr, input logic [29:0] la);
    int  n;
    bit  e_stall, e_hit, push, pop;
    @(negedge clk);
    st_valid = sv; st_addr = a; st_data = d; st_be = b; mem_ready = mr; ld_addr = la;
    #1;
    n = q_addr.size();
    e_stall = (n == 4) && sv && !mr;
    e_hit = 1'b0;
    foreach (q_addr[i]) if (q_addr[i] == la) e_hit = 1'b1;
    chk(buf_full == (n == 4), "R3 full", 64'(buf_full), 64'(n == 4));
    chk(buf_empty == (n == 0), (sv ? "R3 empty" : "R9 empty"), 64'(buf_empty), 64'(n == 0));
    chk(mem_valid == (n != 0), "R8 mem_valid", 64'(mem_valid), 64'(n != 0));
    chk(st_stall == e_stall, ((n == 4 && sv && mr) ? "R5 stall" : "R4 stall"), 64'(st_stall), 64'(e_stall));
    chk(ld_hit == e_hit, "R7 ld_hit", 64'(ld_hit), 64'(e_hit));
    if (n != 0) begin
      chk({mem_addr, mem_data, mem_be} == {q_addr[0], q_data[0], q_be[0]}, "R2 payload",
          64'({mem_addr, mem_be}), 64'({q_addr[0], q_be[0]}));
      chk(mem_data == q_data[0], "R2 data", 64'(mem_data), 64'(q_data[0]));
    end
    if (prev_hold)
      chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data && mem_be == prev_be,
          "R6 hold", 64'({mem_valid, mem_addr}), 64'({1'b1, prev_addr}));
    push = sv && !e_stall;
    pop = (n != 0) && mr;
    prev_hold = (n != 0) && !mr;
    prev_addr = mem_addr; prev_data = mem_data; prev_be = mem_be;
    @(posedge clk);
    if (pop) begin
      void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_be.pop_front());
    end
    if (push) begin
      q_addr.push_back(a); q_data.push_back(d); q_be.push_back(b);
    end
  endtask

  task automatic store(input bit mr, input logic [29:0] la);
    seq++;
    cyc(1'b1, 30'h100 + 30'(seq), 32'hA500_0000 + 32'(seq * 7), 4'(seq), mr, la);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(buf_empty && !buf_full && !mem_valid && !st_stall && !ld_hit, "R1 reset",
        64'({buf_empty, buf_full, mem_valid, st_stall, ld_hit}), 64'h10);
    rst_n = 1'b1;
    // saturation: six stores, DRAM silent (R3, R4)
    for (int k = 0; k < 6; k++) store(1'b0, 30'h101);
    // full with acknowledge: pass-through (R5)
    for (int k = 0; k < 4; k++) store(1'b1, 30'h102);
    // idle store side with junk inputs, DRAM held (R6, R9)
    for (int k = 0; k < 5; k++) cyc(1'b0, 30'h3fff_ffff, 32'hdead_beef, 4'hf, 1'b0, 30'h3fff_ffff);
    // drain in order (R2)
    for (int k = 0; k < 6; k++) cyc(1'b0, 30'h55, 32'h0, 4'h0, 1'b1, 30'h105);
    // single store into empty, no bypass (R8), then hit check (R7)
    store(1'b1, 30'h0);
    cyc(1'b0, 30'h0, 32'h0, 4'h0, 1'b0, 30'h100 + 30'(seq));
    cyc(1'b0, 30'h0, 32'h0, 4'h0, 1'b1, 30'h100 + 30'(seq));
    // mixed pseudo-random traffic
    for (int k = 0; k < 2000; k++) begin
      bit sv, mr;
      logic [29:0] la;
      lfsr = step(lfsr);
      case (k / 500)
        0: begin sv = lfsr[3:0] < 4'd12; mr = lfsr[7:4] < 4'd5; end
        1: begin sv = lfsr[3:0] < 4'd5;  mr = lfsr[7:4] < 4'd12; end
        default: begin sv = lfsr[3]; mr = lfsr[9]; end
      endcase
      la = lfsr[12] ? 30'h100 + 30'(seq - int'(lfsr[14:13])) : 30'(lfsr[29:16]);
      if (sv) begin
        seq++;
        cyc(1'b1, 30'h100 + 30'(seq), lfsr ^ 32'(seq), lfsr[19:16], mr, la);
      end else begin
        cyc(1'b0, 30'(lfsr[31:2]), ~lfsr, lfsr[23:20], mr, la);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule